// File: doc/BRIEF.md
# Operand-Stack Arithmetic Unit

This unit executes a stream of zero-address instructions against an operand stack kept in internal registers. Only two instruction classes name a memory location. The load class reads a word from a synchronous data memory and places it on the stack. The store class removes the top entry and writes it to memory. The arithmetic class names no operands: it takes the two top entries, combines them, and leaves one result in their place. A controller upstream hands over one instruction at a time with a valid/ready handshake. A whole expression can be evaluated this way and its result stored to a memory word.

Each instruction has three fields. The class field is 2 bits. The function field is 2 bits and selects the operation within the arithmetic class. The address field is 8 bits. A load issues its memory read in the cycle it is accepted. The read data returns one cycle later, and the unit is busy during that cycle. Two sticky flags record failures until reset. The underflow flag records a store or arithmetic instruction that found too few entries. The overflow flag records a load attempted onto a full stack.

Top module: `stack_alu_unit`

## Requirements
- R1: After reset the stack is empty, `ovf_flag`, `unf_flag` and `busy` are low and `in_ready` is high.
- R2: An accepted load (class 2'b00) onto a non-full stack drives `mem_rd` high with `mem_addr` equal to the instruction address in the accepting cycle. In the following cycle `busy` is high and `in_ready` is low. The word returned on `mem_rdata` in that cycle becomes the new top entry.
- R3: An accepted store (class 2'b01) on a non-empty stack drives `mem_wr` high in the accepting cycle, with `mem_addr` equal to the instruction address and `mem_wdata` equal to the top entry, and removes that entry.
- R4: Arithmetic (class 2'b10) with function 2'b00 replaces the two top entries with their sum modulo 2^32.
- R5: Arithmetic function 2'b01 replaces the two top entries with the top entry minus the entry below it, modulo 2^32.
- R6: Arithmetic function 2'b10 replaces the two top entries with the low 32 bits of their product.
- R7: A store on an empty stack, or an arithmetic instruction with fewer than two entries, sets `unf_flag`. The flag stays set until reset. No memory write happens and the stack is left unchanged.
- R8: A load onto a stack holding 8 entries issues no memory read, sets `ovf_flag` (which stays set until reset) and leaves the stack unchanged.
- R9: The address field has no effect on arithmetic instructions. Class 2'b11, and arithmetic function 2'b11, leave the stack unchanged.
- R10: Loading E, C, D, multiplying, loading B, adding, subtracting, loading F, adding, loading A, adding and then storing to A leaves B + C*D - E + F + A (modulo 2^32) in location A.
- R11: Entries come back in last-in, first-out order over the full depth of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| in_cls | input | 2 | Class: 00 load, 01 store, 10 arithmetic, 11 no operation |
| in_fn | input | 2 | Arithmetic function: 00 add, 01 subtract, 10 multiply, 11 none |
| in_addr | input | 8 | Memory address for load and store |
| mem_addr | output | 8 | Data memory address |
| mem_rd | output | 1 | Read strobe; data expected one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data (top entry) |
| mem_rdata | input | 32 | Read data, registered by the memory |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |
| busy | output | 1 | Memory read outstanding |

## Verification
The bench builds the unit with its default parameters: 32-bit data, an 8-entry stack and an 8-bit address. It models the whole 256-word memory. With a depth of 8, a full stack and the ninth load are reached in a few instructions, so the bench can fill and drain the stack completely. The arithmetic sweep runs every function over operand pairs chosen to wrap around the 32-bit range. Each expected result is computed in the bench, and the multiply uses a 64-bit product that is then cut to 32 bits.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    CLS_LOAD  = 2'b00,
    CLS_STORE = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_IDLE  = 2'b11
  } stk_cls_e;

  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_SUB  = 2'b01,
    FN_MUL  = 2'b10,
    FN_NONE = 2'b11
  } stk_fn_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        fn,
  input  logic [DATA_W-1:0] first,
  input  logic [DATA_W-1:0] second,
  output logic [DATA_W-1:0] result,
  output logic              fn_valid
);
  import stk_pkg::*;

  function automatic logic [DATA_W-1:0] combine(input logic [1:0] f,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (f)
      FN_ADD:  r = a + b;
      FN_SUB:  r = a - b;
      FN_MUL:  r = a * b;
      default: r = a;
    endcase
    return r;
  endfunction

  assign result   = combine(fn, first, second);
  assign fn_valid = (fn != FN_NONE);
endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_push,
  input  logic              do_pop,
  input  logic              do_fold,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] fold_data,
  output logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] second,
  output logic              full,
  output logic              empty,
  output logic              has_two
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] slot [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx_top, idx_sec, idx_free;

  assign idx_free = IDX_W'(cnt);
  assign idx_top  = IDX_W'(cnt - CNT_W'(1));
  assign idx_sec  = IDX_W'(cnt - CNT_W'(2));
  assign top      = slot[idx_top];
  assign second   = slot[idx_sec];
  assign full     = (cnt == CNT_W'(DEPTH));
  assign empty    = (cnt == '0);
  assign has_two  = (cnt >= CNT_W'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (do_push) begin
      slot[idx_free] <= push_data;
      cnt            <= cnt + CNT_W'(1);
    end else if (do_pop) begin
      cnt <= cnt - CNT_W'(1);
    end else if (do_fold) begin
      slot[idx_sec] <= fold_data;
      cnt           <= cnt - CNT_W'(1);
    end
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |-> !full);
  // R7
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |-> !empty);
  // R7
  fold_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_fold |-> has_two);
  // R11
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_push, do_pop, do_fold}));
  // R11
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/stack_alu_unit.sv
module stack_alu_unit #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_cls,
  input  logic [1:0]        in_fn,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              busy
);
  import stk_pkg::*;

  logic rd_pend;
  logic take, take_load, take_store, take_arith;
  logic rd_issue, wr_issue, fold_go, unf_evt, ovf_evt;
  logic full, empty, has_two, fn_valid;
  logic [DATA_W-1:0] top, second, fold_res;

  assign busy       = rd_pend;
  assign in_ready   = !rd_pend;
  assign take       = in_valid && in_ready;
  assign take_load  = take && (in_cls == CLS_LOAD);
  assign take_store = take && (in_cls == CLS_STORE);
  assign take_arith = take && (in_cls == CLS_ARITH) && fn_valid;

  assign rd_issue = take_load && !full;
  assign wr_issue = take_store && !empty;
  assign fold_go  = take_arith && has_two;
  assign unf_evt  = (take_store && empty) || (take_arith && !has_two);
  assign ovf_evt  = take_load && full;

  assign mem_addr  = in_addr;
  assign mem_rd    = rd_issue;
  assign mem_wr    = wr_issue;
  assign mem_wdata = top;

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .fn       (in_fn),
    .first    (top),
    .second   (second),
    .result   (fold_res),
    .fn_valid (fn_valid)
  );

  stk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_push   (rd_pend),
    .do_pop    (wr_issue),
    .do_fold   (fold_go),
    .push_data (mem_rdata),
    .fold_data (fold_res),
    .top       (top),
    .second    (second),
    .full      (full),
    .empty     (empty),
    .has_two   (has_two)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend  <= 1'b0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      rd_pend  <= rd_issue;
      ovf_flag <= ovf_flag | ovf_evt;
      unf_flag <= unf_flag | unf_evt;
    end
  end

  // R2
  busy_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> busy);
  // R2
  no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  // R3
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R7
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);
  // R7
  no_write_on_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |-> !mem_wr);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  // R8
  no_read_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !mem_rd);
endmodule

// File: tb/stack_alu_unit_tb.sv
module stack_alu_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_cls = 2'b11;
  logic [1:0]  in_fn = 2'b11;
  logic [7:0]  in_addr = '0;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        ovf_flag, unf_flag, busy;

  logic [31:0] mem [256];
  int checks = 0;
  int errors = 0;
  logic seen_rd, seen_wr;

  always #5 clk = ~clk;

  stack_alu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_fn(in_fn), .in_addr(in_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .busy(busy)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  function automatic logic [31:0] initv(input int i);
    return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic op(input logic [1:0] c, input logic [1:0] f, input logic [7:0] a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_cls = c; in_fn = f; in_addr = a;
    #1;
    seen_rd = mem_rd;
    seen_wr = mem_wr;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b, e;
    logic [63:0] p;
    for (int i = 0; i < 256; i++) mem[i] = initv(i);

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 ovf", 32'(ovf_flag), 32'd0);
    chk("R1 unf", 32'(unf_flag), 32'd0);
    op(2'b01, 2'b00, 8'h50);
    chk("R1 empty after reset (store sets unf)", 32'(unf_flag), 32'd1);
    chk("R7 no write on empty store", 32'(seen_wr), 32'd0);
    chk("R7 memory untouched", mem[8'h50], initv(8'h50));

    // R7 arithmetic with one entry leaves the stack unchanged
    mem[8'h51] = 32'h0000_0009;
    op(2'b00, 2'b00, 8'h51);
    op(2'b10, 2'b00, 8'h00);
    chk("R7 unf still set", 32'(unf_flag), 32'd1);
    op(2'b01, 2'b00, 8'h52);
    chk("R7 single entry kept", mem[8'h52], 32'h0000_0009);

    // R2 load timing and busy
    do_reset();
    mem[8'h10] = 32'hCAFE_0001;
    op(2'b00, 2'b00, 8'h10);
    chk("R2 mem_rd issued", 32'(seen_rd), 32'd1);
    chk("R2 busy next cycle", 32'(busy), 32'd1);
    chk("R2 in_ready low next cycle", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R2 busy drops", 32'(busy), 32'd0);
    op(2'b01, 2'b00, 8'h90);
    chk("R3 write strobe", 32'(seen_wr), 32'd1);
    chk("R2 loaded word stored back", mem[8'h90], 32'hCAFE_0001);

    // R11 fill full depth, R8 overflow, R11 LIFO drain
    do_reset();
    for (int i = 0; i < 8; i++) begin
      mem[8'h10 + i] = 32'h1000_0000 + 32'(i) * 32'h0101_0011;
      op(2'b00, 2'b00, 8'(8'h10 + i));
    end
    chk("R8 no ovf at 8 entries", 32'(ovf_flag), 32'd0);
    mem[8'h18] = 32'hDEAD_BEEF;
    op(2'b00, 2'b00, 8'h18);
    chk("R8 no read when full", 32'(seen_rd), 32'd0);
    chk("R8 ovf set", 32'(ovf_flag), 32'd1);
    for (int i = 0; i < 8; i++) begin
      op(2'b01, 2'b00, 8'(8'h80 + i));
      chk("R11 lifo order", mem[8'h80 + i], 32'h1000_0000 + 32'(7 - i) * 32'h0101_0011);
    end
    chk("R8 ovf sticky", 32'(ovf_flag), 32'd1);
    chk("R11 no unf over full drain", 32'(unf_flag), 32'd0);

    // R4 R5 R6 arithmetic sweep
    do_reset();
    for (int pi = 0; pi < 4; pi++) begin
      a = 32'hFFFF_FFFF - 32'(pi) * 32'h1234_5679;
      b = 32'(pi) * 32'h0F0F_0F0F + 32'd3;
      if (pi == 3) a = 32'd0;
      for (int fi = 0; fi < 3; fi++) begin
        mem[8'h20] = b;
        mem[8'h21] = a;
        op(2'b00, 2'b00, 8'h20);
        op(2'b00, 2'b00, 8'h21);
        op(2'b10, 2'(fi), 8'h33);
        op(2'b01, 2'b00, 8'h40);
        if (fi == 0) begin
          e = a + b;
          chk("R4 add", mem[8'h40], e);
        end else if (fi == 1) begin
          e = a - b;
          chk("R5 sub top minus next", mem[8'h40], e);
        end else begin
          p = {32'd0, a} * {32'd0, b};
          chk("R6 mul low half", mem[8'h40], p[31:0]);
        end
      end
    end
    chk("R9 arith address unused", mem[8'h33], initv(8'h33));
    chk("R7 no unf in sweep", 32'(unf_flag), 32'd0);

    // R9 no-op class and function
    mem[8'h22] = 32'd3;
    mem[8'h23] = 32'd4;
    op(2'b00, 2'b00, 8'h22);
    op(2'b00, 2'b00, 8'h23);
    op(2'b11, 2'b00, 8'h23);
    op(2'b10, 2'b11, 8'h23);
    op(2'b01, 2'b00, 8'h41);
    chk("R9 no-op keeps top", mem[8'h41], 32'd4);
    op(2'b01, 2'b00, 8'h42);
    chk("R9 no-op keeps next", mem[8'h42], 32'd3);
    chk("R9 no unf from no-ops", 32'(unf_flag), 32'd0);

    // R10 expression
    do_reset();
    mem[8'h61] = 32'd7;           // A
    mem[8'h62] = 32'd100;         // B
    mem[8'h63] = 32'h0012_3456;   // C
    mem[8'h64] = 32'h0000_4321;   // D
    mem[8'h65] = 32'd50_000;      // E
    mem[8'h66] = 32'h8000_0009;   // F
    p = {32'd0, mem[8'h63]} * {32'd0, mem[8'h64]};
    e = mem[8'h62] + p[31:0] - mem[8'h65] + mem[8'h66] + mem[8'h61];
    op(2'b00, 2'b00, 8'h65);
    op(2'b00, 2'b00, 8'h63);
    op(2'b00, 2'b00, 8'h64);
    op(2'b10, 2'b10, 8'h00);
    op(2'b00, 2'b00, 8'h62);
    op(2'b10, 2'b00, 8'h00);
    op(2'b10, 2'b01, 8'h00);
    op(2'b00, 2'b00, 8'h66);
    op(2'b10, 2'b00, 8'h00);
    op(2'b00, 2'b00, 8'h61);
    op(2'b10, 2'b00, 8'h00);
    op(2'b01, 2'b00, 8'h61);
    chk("R10 expression result", mem[8'h61], e);
    chk("R10 no flags", {30'd0, ovf_flag, unf_flag}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule